// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block turns the source and destination sizes of a single display plane into the phase settings a scaling engine needs. A request carries the source width and height in whole pixels, the destination width and height, a flag that marks a quarter-turn (90 or 270 degree) rotation, and a bit mask of the planes that ask for scaling. The block works out which sizes feed the scaler and then derives, for each axis, a starting phase and a per-pixel phase step. It also decides whether the detail enhancer should be switched on.

Work begins with a one-cycle `start_i` strobe and ends with a one-cycle `done_o` pulse. Some requests cannot be served: more than one plane asks for scaling, or a destination size is zero. These requests finish at once with `err_o` set. A request with an empty mask finishes at once with scaling off. Every other request runs four divisions, one after another, on one shared restoring divider. The results appear together with `done_o` and hold until the next request finishes.

Top module: `scaler_phase_calc`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `err_o`, `scale_en_o`, `enh_en_o` and every dimension and phase output are zero.
- R2: When an accepted request's mask has two or more bits set, `done_o` rises in the cycle after the accepting edge. At the same time `err_o` is 1, `scale_en_o` is 0, and all dimension, phase and enhancer outputs are 0.
- R3: When an accepted request's mask is zero, `done_o` rises in the cycle after the accepting edge. At the same time `err_o`, `scale_en_o` and all dimension, phase and enhancer outputs are 0.
- R4: A request with exactly one mask bit set and a destination width or height of zero is handled like R2: it gets an immediate `done_o` with `err_o` at 1 and every other result zero.
- R5: When `rotated_i` is 1, the effective input width is the source height and the effective input height is the source width. When it is 0, they are the source width and height.
- R6: The initial phase of each axis is floor((floor(in*16/out) + 1) / 2). Here `in` and `out` are that axis's effective input size and destination size.
- R7: The phase step of each axis is floor(in*65536/out). It is exact across the full dimension range, including in = 2^DIM_W-1 and out = 1.
- R8: `enh_en_o` is 1 exactly when the integer part of out/in is at least 2 on either axis, that is when out >= 2*in.
- R9: A valid scaling request keeps `busy_o` high and raises `done_o` 4*(DIV_W+2) cycles after the accepting edge, where DIV_W = DIM_W+16. On success `scale_en_o` is 1 and `err_o` is 0.
- R10: `done_o` is high for exactly one cycle. The result outputs change only in the cycle `done_o` is high.
- R11: A `start_i` raised while `busy_o` is high is ignored. It does not change the result, the error flag or the finish time of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| src_w_i | input | DIM_W | Source width in pixels |
| src_h_i | input | DIM_W | Source height in pixels |
| dst_w_i | input | DIM_W | Destination width in pixels |
| dst_h_i | input | DIM_W | Destination height in pixels |
| rotated_i | input | 1 | Quarter-turn rotation flag |
| scale_mask_i | input | MASK_W | One bit per plane asking for scaling |
| busy_o | output | 1 | Division sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected |
| scale_en_o | output | 1 | Scaling enabled with valid phases |
| enh_en_o | output | 1 | Detail enhancer enable |
| in_w_o | output | DIM_W | Effective input width |
| in_h_o | output | DIM_W | Effective input height |
| h_init_o | output | DIV_W | Horizontal initial phase |
| h_delta_o | output | DIV_W | Horizontal phase step |
| v_init_o | output | DIV_W | Vertical initial phase |
| v_delta_o | output | DIV_W | Vertical phase step |

## Verification
The bench builds the block with its defaults, DIM_W = 16 and MASK_W = 8. That gives a 32-bit divider and a 136-cycle sequence. A 16-bit dimension shifted by sixteen fills the dividend completely, so the widest case (65535 against 1) tests every quotient bit and the carry out of the partial remainder. Eight mask bits leave room for masks with one bit, two bits and no bits, and for bits that are not adjacent.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  // order of the four quotients on the shared divider
  typedef enum logic [1:0] {
    SL_H_INIT  = 2'd0,
    SL_H_STEP  = 2'd1,
    SL_V_INIT  = 2'd2,
    SL_V_STEP  = 2'd3
  } quot_slot_e;

endpackage

// File: rtl/scp_req_check.sv
module scp_req_check #(
  parameter int DIM_W  = 16,
  parameter int MASK_W = 8
) (
  input  logic [DIM_W-1:0]  src_w_i,
  input  logic [DIM_W-1:0]  src_h_i,
  input  logic [DIM_W-1:0]  dst_w_i,
  input  logic [DIM_W-1:0]  dst_h_i,
  input  logic              rotated_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [DIM_W-1:0]  eff_w_o,
  output logic [DIM_W-1:0]  eff_h_o,
  output logic              multi_o,
  output logic              none_o,
  output logic              zero_out_o,
  output logic              enh_o
);

  localparam int CNT_W = $clog2(MASK_W + 1);

  function automatic logic [CNT_W-1:0] bits_set(input logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < MASK_W; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  // integer part of out/in reaches two exactly when out >= 2*in
  function automatic logic upscale_ge2(input logic [DIM_W-1:0] outd,
                                       input logic [DIM_W-1:0] ind);
    return {1'b0, outd} >= {ind, 1'b0};
  endfunction

  logic [CNT_W-1:0] req_count;

  assign req_count  = bits_set(mask_i);
  assign multi_o    = req_count > CNT_W'(1);
  assign none_o     = (req_count == '0);
  assign zero_out_o = (dst_w_i == '0) || (dst_h_i == '0);
  assign eff_w_o    = rotated_i ? src_h_i : src_w_i;
  assign eff_h_o    = rotated_i ? src_w_i : src_h_i;
  assign enh_o      = upscale_ge2(dst_w_i, eff_w_o) || upscale_ge2(dst_h_i, eff_h_o);

endmodule

// File: rtl/scp_divider.sv
module scp_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quot_o
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, fin_q;
  logic [W:0]    partial, trial;
  logic          trial_neg;

  assign partial   = {rem_q, quo_q[W-1]};
  assign trial     = partial - {1'b0, dvs_q};
  assign trial_neg = trial[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= STEPS;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (trial_neg) begin
          rem_q <= partial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = fin_q;
  assign quot_o = quo_q;

  // R9: the sequencer never loads a quotient on top of one in flight
  a_r9_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);

  // R9: each quotient is reported once
  a_r9_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);

  // R7: the remainder stays below the divisor while iterating
  a_r7_rem_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc #(
  parameter int DIM_W  = 16,
  parameter int MASK_W = 8,
  localparam int PH_BITS   = 4,
  localparam int STEP_SH   = PH_BITS + 12,
  localparam int DIV_W     = DIM_W + STEP_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  src_w_i,
  input  logic [DIM_W-1:0]  src_h_i,
  input  logic [DIM_W-1:0]  dst_w_i,
  input  logic [DIM_W-1:0]  dst_h_i,
  input  logic              rotated_i,
  input  logic [MASK_W-1:0] scale_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              scale_en_o,
  output logic              enh_en_o,
  output logic [DIM_W-1:0]  in_w_o,
  output logic [DIM_W-1:0]  in_h_o,
  output logic [DIV_W-1:0]  h_init_o,
  output logic [DIV_W-1:0]  h_delta_o,
  output logic [DIV_W-1:0]  v_init_o,
  output logic [DIV_W-1:0]  v_delta_o
);

  import scp_pkg::*;

  localparam int PAD_W = DIV_W - DIM_W;

  // (q + 1) / 2 written without a wider adder
  function automatic logic [DIV_W-1:0] half_up(input logic [DIV_W-1:0] q);
    return (q >> 1) + DIV_W'(q[0]);
  endfunction

  function automatic logic [DIV_W-1:0] widen_shift(input logic [DIM_W-1:0] v,
                                                   input int sh);
    return {{PAD_W{1'b0}}, v} << sh;
  endfunction

  // ---------------- request screening ----------------
  logic [DIM_W-1:0] chk_eff_w, chk_eff_h;
  logic             chk_multi, chk_none, chk_zero_out, chk_enh;

  scp_req_check #(.DIM_W(DIM_W), .MASK_W(MASK_W)) u_check (
    .src_w_i    (src_w_i),
    .src_h_i    (src_h_i),
    .dst_w_i    (dst_w_i),
    .dst_h_i    (dst_h_i),
    .rotated_i  (rotated_i),
    .mask_i     (scale_mask_i),
    .eff_w_o    (chk_eff_w),
    .eff_h_o    (chk_eff_h),
    .multi_o    (chk_multi),
    .none_o     (chk_none),
    .zero_out_o (chk_zero_out),
    .enh_o      (chk_enh)
  );

  // ---------------- named events ----------------
  seq_state_e state_q;
  quot_slot_e slot_q;
  logic       accept, reject_now, skip_now, run_now;

  assign accept     = start_i && (state_q == ST_IDLE);
  assign reject_now = accept && (chk_multi || (!chk_none && chk_zero_out));
  assign skip_now   = accept && chk_none;
  assign run_now    = accept && !reject_now && !skip_now;

  // ---------------- latched request ----------------
  logic [DIM_W-1:0] in_w_q, in_h_q, out_w_q, out_h_q;
  logic             enh_q;

  // ---------------- shared divider ----------------
  logic             div_go, div_busy, div_fin;
  logic [DIV_W-1:0] div_dvd, div_dvs, div_quot;

  assign div_go = (state_q == ST_ISSUE);

  always_comb begin
    unique case (slot_q)
      SL_H_INIT: begin div_dvd = widen_shift(in_w_q, PH_BITS); div_dvs = widen_shift(out_w_q, 0); end
      SL_H_STEP: begin div_dvd = widen_shift(in_w_q, STEP_SH); div_dvs = widen_shift(out_w_q, 0); end
      SL_V_INIT: begin div_dvd = widen_shift(in_h_q, PH_BITS); div_dvs = widen_shift(out_h_q, 0); end
      default:   begin div_dvd = widen_shift(in_h_q, STEP_SH); div_dvs = widen_shift(out_h_q, 0); end
    endcase
  end

  scp_divider #(.W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (div_go),
    .dividend_i (div_dvd),
    .divisor_i  (div_dvs),
    .busy_o     (div_busy),
    .fin_o      (div_fin),
    .quot_o     (div_quot)
  );

  logic last_quot;
  assign last_quot = (state_q == ST_WAIT) && div_fin && (slot_q == SL_V_STEP);

  // ---------------- staging and published results ----------------
  logic [DIV_W-1:0] h_init_s, h_step_s, v_init_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      slot_q     <= SL_H_INIT;
      in_w_q     <= '0;
      in_h_q     <= '0;
      out_w_q    <= '0;
      out_h_q    <= '0;
      enh_q      <= 1'b0;
      h_init_s   <= '0;
      h_step_s   <= '0;
      v_init_s   <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      scale_en_o <= 1'b0;
      enh_en_o   <= 1'b0;
      in_w_o     <= '0;
      in_h_o     <= '0;
      h_init_o   <= '0;
      h_delta_o  <= '0;
      v_init_o   <= '0;
      v_delta_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (reject_now || skip_now) begin
            done_o     <= 1'b1;
            err_o      <= reject_now;
            scale_en_o <= 1'b0;
            enh_en_o   <= 1'b0;
            in_w_o     <= '0;
            in_h_o     <= '0;
            h_init_o   <= '0;
            h_delta_o  <= '0;
            v_init_o   <= '0;
            v_delta_o  <= '0;
          end else if (run_now) begin
            in_w_q  <= chk_eff_w;
            in_h_q  <= chk_eff_h;
            out_w_q <= dst_w_i;
            out_h_q <= dst_h_i;
            enh_q   <= chk_enh;
            slot_q  <= SL_H_INIT;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_fin) begin
            unique case (slot_q)
              SL_H_INIT: begin h_init_s <= half_up(div_quot); slot_q <= SL_H_STEP; state_q <= ST_ISSUE; end
              SL_H_STEP: begin h_step_s <= div_quot;          slot_q <= SL_V_INIT; state_q <= ST_ISSUE; end
              SL_V_INIT: begin v_init_s <= half_up(div_quot); slot_q <= SL_V_STEP; state_q <= ST_ISSUE; end
              default: begin
                done_o     <= 1'b1;
                err_o      <= 1'b0;
                scale_en_o <= 1'b1;
                enh_en_o   <= enh_q;
                in_w_o     <= in_w_q;
                in_h_o     <= in_h_q;
                h_init_o   <= h_init_s;
                h_delta_o  <= h_step_s;
                v_init_o   <= v_init_s;
                v_delta_o  <= div_quot;
                state_q    <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // ---------------- assertions ----------------
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(h_delta_o) && $stable(v_delta_o) && $stable(h_init_o)
                 && $stable(v_init_o) && $stable(err_o) && $stable(scale_en_o)));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r9_divider_matches_seq: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state_q == ST_WAIT));

  a_r9_last_is_done: assert property (@(posedge clk) disable iff (!rst_n)
    last_quot |=> (done_o && scale_en_o && !err_o));

  a_r2_multi_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && $countones(scale_mask_i) > 1) |=> (done_o && err_o && !scale_en_o));

  a_r3_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && scale_mask_i == '0) |=> (done_o && !err_o && !scale_en_o));

  a_r4_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && $countones(scale_mask_i) == 1 && (dst_w_i == '0 || dst_h_i == '0))
      |=> (done_o && err_o));

  a_r2_err_excludes_scale: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !scale_en_o);

  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

endmodule

// File: tb/scaler_phase_calc_tb_top.sv
module scaler_phase_calc_tb_top;

  localparam int DIM_W  = 16;
  localparam int MASK_W = 8;
  localparam int DIV_W  = DIM_W + 16;
  localparam int LAT    = 4 * (DIV_W + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic              start;
  logic [DIM_W-1:0]  sw, sh, dw, dh;
  logic              rot;
  logic [MASK_W-1:0] mask;
  logic              busy, done, err, sc_en, enh;
  logic [DIM_W-1:0]  in_w, in_h;
  logic [DIV_W-1:0]  h_init, h_delta, v_init, v_delta;

  scaler_phase_calc #(.DIM_W(DIM_W), .MASK_W(MASK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .src_w_i(sw), .src_h_i(sh), .dst_w_i(dw), .dst_h_i(dh),
    .rotated_i(rot), .scale_mask_i(mask),
    .busy_o(busy), .done_o(done), .err_o(err), .scale_en_o(sc_en), .enh_en_o(enh),
    .in_w_o(in_w), .in_h_o(in_h),
    .h_init_o(h_init), .h_delta_o(h_delta), .v_init_o(v_init), .v_delta_o(v_delta)
  );

  typedef struct {
    bit     err, sc, enh, quick;
    longint iw, ih, hi, hd, vi, vd;
  } res_t;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";

  function automatic res_t predict(longint a_sw, longint a_sh, longint a_dw, longint a_dh,
                                   bit a_rot, logic [MASK_W-1:0] a_mask);
    res_t r;
    longint ew, eh;
    r = '{default: 0};
    ew = a_rot ? a_sh : a_sw;
    eh = a_rot ? a_sw : a_sh;
    if ($countones(a_mask) >= 2 || (a_mask != 0 && (a_dw == 0 || a_dh == 0))) begin
      r.err = 1; r.quick = 1;
    end else if (a_mask == 0) begin
      r.quick = 1;
    end else begin
      r.sc  = 1;
      r.iw  = ew; r.ih = eh;
      r.hi  = ((ew * 16) / a_dw + 1) / 2;
      r.vi  = ((eh * 16) / a_dh + 1) / 2;
      r.hd  = (ew * 65536) / a_dw;
      r.vd  = (eh * 65536) / a_dh;
      r.enh = (a_dw >= 2 * ew) || (a_dh >= 2 * eh);
    end
    return r;
  endfunction

  // ---------------- cycle model ----------------
  res_t m_out, m_pend;
  bit   m_busy, m_done;
  int   m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '{default: 0}; m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_out = m_pend; end
      end else if (start) begin
        m_pend = predict(sw, sh, dw, dh, rot, mask);
        if (m_pend.quick) begin m_done = 1; m_out = m_pend; end
        else begin m_busy = 1; m_cnt = LAT; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (done !== m_done || busy !== m_busy || err !== m_out.err || sc_en !== m_out.sc ||
          enh !== m_out.enh || longint'(in_w) != m_out.iw || longint'(in_h) != m_out.ih ||
          longint'(h_init) != m_out.hi || longint'(h_delta) != m_out.hd ||
          longint'(v_init) != m_out.vi || longint'(v_delta) != m_out.vd) begin
        n_bad++;
        $display("FAIL %s: got done=%0b busy=%0b err=%0b sc=%0b enh=%0b iw=%0d ih=%0d hi=%0d hd=%0d vi=%0d vd=%0d exp done=%0b busy=%0b err=%0b sc=%0b enh=%0b iw=%0d ih=%0d hi=%0d hd=%0d vi=%0d vd=%0d",
                 tag, done, busy, err, sc_en, enh, in_w, in_h, h_init, h_delta, v_init, v_delta,
                 m_done, m_busy, m_out.err, m_out.sc, m_out.enh, m_out.iw, m_out.ih,
                 m_out.hi, m_out.hd, m_out.vi, m_out.vd);
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check_lat(int got, int exp_n, string t);
    n_cmp++;
    if (got != exp_n) begin
      n_bad++;
      $display("FAIL %s latency: got %0d expected %0d", t, got, exp_n);
    end
  endtask

  task automatic request(int a_sw, int a_sh, int a_dw, int a_dh, bit a_rot,
                         logic [MASK_W-1:0] a_mask, string t);
    int n;
    bit quick;
    tag = t;
    quick = predict(a_sw, a_sh, a_dw, a_dh, a_rot, a_mask).quick;
    @(negedge clk);
    sw = DIM_W'(a_sw); sh = DIM_W'(a_sh); dw = DIM_W'(a_dw); dh = DIM_W'(a_dh);
    rot = a_rot; mask = a_mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    check_lat(n, quick ? 0 : LAT, t);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    start = 0; sw = 0; sh = 0; dw = 0; dh = 0; rot = 0; mask = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, also covered by the per-cycle model compare
    n_cmp++;
    if (done || busy || err || sc_en || enh || h_delta != 0 || v_delta != 0) begin
      n_bad++;
      $display("FAIL R1: got done=%0b busy=%0b err=%0b expected all zero", done, busy, err);
    end
    repeat (2) @(negedge clk);

    request(1920, 1080, 1280, 720, 0, 8'b0000_0001, "R6_R7_downscale");
    request(100, 50, 300, 90, 1, 8'b0000_0100, "R5_R8_rotated");
    request(10, 10, 19, 19, 0, 8'b0001_0000, "R8_below_two");
    request(10, 10, 20, 10, 0, 8'b0001_0000, "R8_exactly_two");
    request(65535, 1, 1, 65535, 0, 8'b1000_0000, "R7_widest");
    request(640, 480, 640, 480, 1, 8'b0000_0010, "R5_R9_unity");
    request(640, 480, 320, 240, 0, 8'b0000_0101, "R2_two_planes");
    request(640, 480, 320, 240, 0, 8'b1000_0001, "R2_far_bits");
    request(640, 480, 320, 240, 0, 8'b0000_0000, "R3_no_plane");
    request(640, 480, 0, 240, 0, 8'b0000_1000, "R4_zero_width");
    request(640, 480, 320, 0, 1, 8'b0000_1000, "R4_zero_height");
    request(3, 7, 1000, 999, 0, 8'b0100_0000, "R6_R10_upscale");

    // R11: second strobe during the sequence is dropped
    tag = "R11_ignored";
    @(negedge clk);
    sw = 800; sh = 600; dw = 1024; dh = 768; rot = 0; mask = 8'b0010_0000; start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    mask = 8'b0000_0011; dw = 0; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 40000) @(negedge clk);
    n_cmp++;
    if (err !== 1'b0 || sc_en !== 1'b1) begin
      n_bad++;
      $display("FAIL R11: got err=%0b sc=%0b expected err=0 sc=1", err, sc_en);
    end
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule